// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the bytes of each received Ethernet frame as they stream past and produces a single keep/drop verdict per frame. It looks at the destination address, which is the first six bytes of the frame, and classifies it as broadcast, multicast or unicast. A unicast frame is kept only when its destination equals the programmed station address. A broadcast frame is kept under a broadcast enable. A multicast frame is kept under a multicast enable, and only when a bit in a small hash table selects it. The table bit is picked by a CRC computed over the destination address. Policies for short (runt) frames and for frames flagged with a bad FCS can reject a frame that the address check would have passed.

The stream input uses a valid/ready handshake. The filter never applies back-pressure. `in_ready` is low during reset and high in every cycle after it. A byte is taken on any rising clock edge where `in_valid` and `in_ready` are both high. Idle cycles (`in_valid` low) may appear anywhere inside a frame and do not change the result. A separate write-only configuration port loads the enables, the station address and the hash table. The frame being received is judged against a snapshot of the configuration taken at its start-of-frame byte.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: `in_ready` is 0 in reset and 1 afterwards. A byte taken while no frame is open and without `in_sof` is ignored and produces no decision.
- R2: For each frame, `dec_valid` is high for exactly the one cycle after the clock edge that took the byte carrying `in_eof`. `dec_accept` is high only together with `dec_valid`.
- R3: The address bytes are numbered in arrival order, byte 0 first. All-ones (FF:FF:FF:FF:FF:FF) is broadcast. Otherwise bit 0 of byte 0 set means multicast, and anything else is unicast. A unicast frame is accepted only when it equals the station address.
- R4: A destination equal to the station address is accepted whatever the broadcast/multicast enables and the hash table hold.
- R5: A broadcast frame that does not match the station address is accepted only while the broadcast enable is 1.
- R6: A multicast frame that does not match the station address is accepted only when the multicast enable is 1 and hash-table bit `idx` is 1. The CRC register starts at 0xFFFFFFFF and takes the address bytes in order, each byte LSB first. For each input bit, let fb = crc[0] XOR bit. The register shifts right by one, and is then XORed with 0xC704DD7B when fb is 1. `idx` is bits [3:0] of the register after the sixth byte, with no final inversion.
- R7: A table of 0xFFFF accepts every multicast frame when the multicast enable is 1. A table of 0x0000 rejects every multicast frame that does not match the station address.
- R8: A frame of fewer than 64 bytes (SOF byte through EOF byte) is rejected unless the runt enable is 1. A frame of 64 bytes is not a runt.
- R9: A frame whose `in_crc_ok` is 0 on its EOF byte is rejected unless the CRC-error enable is 1.
- R10: A frame of fewer than 6 bytes is always rejected.
- R11: After reset, the broadcast and multicast enables are 1, the runt and CRC-error enables are 0, the hash table is 0x0400 and the station address is 0.
- R12: A configuration write takes effect from the next start-of-frame byte taken after the write edge. A write made while a frame is open does not change that frame's verdict.
- R13: Configuration writes use `cfg_addr` as follows. Address 0 holds the enables: bit0 broadcast, bit1 multicast, bit2 runt, bit3 CRC-error. Address 1 holds station bytes 0 (bits 7:0) and 1 (bits 15:8). Address 2 holds station bytes 2 and 3. Address 3 holds station bytes 4 and 5. Address 4 holds the hash table, with bit n being entry n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, high whenever out of reset |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_crc_ok | input | 1 | FCS-good flag, sampled with the EOF byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The hardest case to reach from the ports is a multicast frame whose hash index lands on one particular table bit. The index comes out of a 32-bit CRC, so there is no direct way to aim at a bit. The bench computes the hash itself and sweeps the last address byte to find addresses that land on index 10 and addresses that miss it. This lets it test the reset table value in both directions. The same approach is used for a single programmed bit. A second hard case is a configuration change that arrives in the middle of a frame. The bench issues the write on a chosen byte of an open frame, then checks that this frame keeps the old verdict and that the next frame gets the new one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ADDR_BYTES = 6;
  localparam logic [31:0] HASH_POLY = 32'hC704DD7B;

  typedef logic [ADDR_BYTES-1:0][7:0] mac_t;

  // bit0 broadcast, bit1 multicast, bit2 runt, bit3 crc-error
  typedef struct packed {
    logic crcerr_en;
    logic runt_en;
    logic mc_en;
    logic bc_en;
  } rxf_en_t;

  typedef enum logic [2:0] {
    SEL_ENABLES = 3'd0,
    SEL_STA_01  = 3'd1,
    SEL_STA_23  = 3'd2,
    SEL_STA_45  = 3'd3,
    SEL_HASH    = 3'd4
  } cfg_sel_e;

  localparam rxf_en_t EN_RESET = '{crcerr_en: 1'b0, runt_en: 1'b0, mc_en: 1'b1, bc_en: 1'b1};

  // one byte through the hash register, least significant bit first
  function automatic logic [31:0] crc_step8(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ HASH_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int TBL_W = 16,
  parameter int CFG_W = 16,
  parameter logic [TBL_W-1:0] RST_TABLE = 'h0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             snap,
  input  logic             frame_open,
  output rxf_en_t          act_en,
  output mac_t             act_sta,
  output logic [TBL_W-1:0] act_tbl
);

  rxf_en_t          prg_en;
  mac_t             prg_sta;
  logic [TBL_W-1:0] prg_tbl;

  // programmed copy, written by the port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_en  <= EN_RESET;
      prg_sta <= '0;
      prg_tbl <= RST_TABLE;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_addr))
        SEL_ENABLES: prg_en <= rxf_en_t'(cfg_wdata[3:0]);
        SEL_STA_01:  begin prg_sta[0] <= cfg_wdata[7:0]; prg_sta[1] <= cfg_wdata[15:8]; end
        SEL_STA_23:  begin prg_sta[2] <= cfg_wdata[7:0]; prg_sta[3] <= cfg_wdata[15:8]; end
        SEL_STA_45:  begin prg_sta[4] <= cfg_wdata[7:0]; prg_sta[5] <= cfg_wdata[15:8]; end
        SEL_HASH:    prg_tbl <= cfg_wdata[TBL_W-1:0];
        default:     ;
      endcase
    end
  end

  // active copy, refreshed only at a start-of-frame byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en  <= EN_RESET;
      act_sta <= '0;
      act_tbl <= RST_TABLE;
    end else if (snap) begin
      act_en  <= prg_en;
      act_sta <= prg_sta;
      act_tbl <= prg_tbl;
    end
  end

  // R12: settings seen by an open frame do not move until the next start
  a_r12_frozen_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_open && !snap) |=> ($stable(act_en) && $stable(act_sta) && $stable(act_tbl)));

endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
  import rxf_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int CNT_W   = $clog2(MIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic [7:0]       data,
  output logic             take,
  output logic             addr_beat,
  output logic             frame_open,
  output logic [CNT_W-1:0] cnt_nxt,
  output mac_t             da_nxt
);

  localparam logic [CNT_W-1:0] LEN_CAP = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] DA_LEN  = CNT_W'(ADDR_BYTES);

  logic             in_frame;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pos;
  mac_t             da_q;

  assign frame_open = in_frame;
  assign take       = beat && (sof || in_frame);
  assign pos        = sof ? '0 : cnt;
  assign addr_beat  = take && (pos < DA_LEN);
  assign cnt_nxt    = (pos == LEN_CAP) ? pos : pos + 1'b1;

  always_comb begin
    da_nxt = da_q;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (addr_beat && pos == CNT_W'(k)) da_nxt[k] = data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      da_q     <= '0;
    end else if (take) begin
      in_frame <= !eof;
      cnt      <= cnt_nxt;
      da_q     <= da_nxt;
    end
  end

  // R8: length count saturates at the runt limit
  a_r8_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LEN_CAP);

  // R1: a frame only opens through a start-of-frame byte
  a_r1_open_by_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(beat && sof));

endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 first,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] idx_nxt
);

  logic [31:0] crc_q;
  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (upd) crc_d = crc_step8(first ? 32'hFFFF_FFFF : crc_q, data);
  end

  assign idx_nxt = crc_d[HASH_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= 32'hFFFF_FFFF;
    else if (upd) crc_q <= crc_d;
  end

  // R6: the hash register only moves on address bytes
  a_r6_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(crc_q));

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 4,
  parameter int MIN_LEN   = 64,
  parameter int CFG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             dec_valid,
  output logic             dec_accept
);

  localparam int TBL_W = 1 << HASH_BITS;
  localparam int CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] DA_LEN  = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] RUNT_LM = CNT_W'(MIN_LEN);

  logic                 beat, take, addr_beat, frame_open, snap, end_beat;
  logic [CNT_W-1:0]     cnt_nxt;
  mac_t                 da_nxt;
  logic [HASH_BITS-1:0] idx_nxt;
  rxf_en_t              act_en;
  mac_t                 act_sta;
  logic [TBL_W-1:0]     act_tbl;
  logic                 is_bc, is_mc, sta_hit, addr_ok, len_full, runt, verdict;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign beat     = in_valid && in_ready;
  assign snap     = take && in_sof;
  assign end_beat = take && in_eof;

  rxf_cfg_regs #(.TBL_W(TBL_W), .CFG_W(CFG_W), .RST_TABLE(TBL_W'('h0400))) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .snap(snap), .frame_open(frame_open),
    .act_en(act_en), .act_sta(act_sta), .act_tbl(act_tbl));

  rxf_frame_track #(.MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .eof(in_eof), .data(in_data),
    .take(take), .addr_beat(addr_beat), .frame_open(frame_open),
    .cnt_nxt(cnt_nxt), .da_nxt(da_nxt));

  rxf_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk(clk), .rst_n(rst_n), .upd(addr_beat), .first(in_sof), .data(in_data),
    .idx_nxt(idx_nxt));

  // classification and policy, evaluated on the EOF byte
  always_comb begin
    is_bc    = &da_nxt;
    is_mc    = da_nxt[0][0] && !is_bc;
    sta_hit  = (da_nxt == act_sta);
    addr_ok  = sta_hit
             || (is_bc && act_en.bc_en)
             || (is_mc && act_en.mc_en && act_tbl[idx_nxt]);
    len_full = (cnt_nxt >= DA_LEN);
    runt     = (cnt_nxt < RUNT_LM);
    verdict  = addr_ok && len_full
             && (!runt || act_en.runt_en)
             && (in_crc_ok || act_en.crcerr_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= end_beat;
      dec_accept <= end_beat && verdict;
    end
  end

  // R2: accept is qualified by the strobe
  a_r2_accept_qual: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  // R2: a verdict follows a byte carrying end-of-frame
  a_r2_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_eof));

  // R10: a frame without a full address is never kept
  a_r10_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && !len_full) |=> !dec_accept);

  // R5: broadcast with the enable cleared and no station match is dropped
  a_r5_bc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && is_bc && !act_en.bc_en && !sta_hit) |=> !dec_accept);

endmodule

// File: tb/sim_eth_rx_addr_filter.sv
module sim_eth_rx_addr_filter;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'hC704DD7B;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STA   = 48'h0C0A_0806_0402;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_crc_ok = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_ready, dec_valid, dec_accept;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_ok(in_crc_ok),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ a[8*k+b]) c = (c >> 1) ^ POLY;
        else                 c = c >> 1;
      end
    return c[3:0];
  endfunction

  // multicast address (byte0 = 01) whose index equals / differs from want
  function automatic logic [47:0] find_mc(input logic [3:0] want, input bit eq);
    logic [47:0] a;
    for (int v = 0; v < 256; v++) begin
      a = {v[7:0], 32'h005E_0000, 8'h01};
      if ((hidx(a) == want) == eq) return a;
    end
    return 48'h0;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_station(input logic [47:0] s);
    cfg_write(3'd1, s[15:0]);
    cfg_write(3'd2, s[31:16]);
    cfg_write(3'd3, s[47:32]);
  endtask

  // one frame, optional idle gap and optional mid-frame write at byte 10
  task automatic send_frame(input logic [47:0] da, input int len, input bit crc_ok,
                            input bit gap, input bit exp, input string req,
                            input bit mw = 0, input logic [2:0] ma = 0, input logic [15:0] md = 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_crc_ok = (i == len - 1) ? crc_ok : 1'b0;
      in_data   = (i < 6) ? da[8*i +: 8] : (i[7:0] ^ 8'h5A);
      cfg_we    = mw && (i == 10);
      cfg_addr  = ma;
      cfg_wdata = md;
      if (gap && i == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
      end
      if (i != len - 1) begin
        @(posedge clk);
        check(dec_valid == 1'b0, {req, " no verdict mid-frame (R2)"}, 32'(dec_valid), 0);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
    check(dec_valid == 1'b1, {req, " verdict strobe (R2)"}, 32'(dec_valid), 1);
    check(dec_accept == exp, req, 32'(dec_accept), 32'(exp));
    @(negedge clk);
    check(dec_valid == 1'b0 && dec_accept == 1'b0, {req, " strobe one cycle (R2)"}, 32'(dec_valid), 0);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b0 && dec_valid == 1'b0, "R1 ready low in reset", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 1);
    check(dec_valid == 1'b0 && dec_accept == 1'b0, "R11 no verdict after reset", 32'(dec_valid), 0);
  endtask

  task automatic t_defaults;
    logic [47:0] hit10, miss10;
    hit10  = find_mc(4'd10, 1'b1);
    miss10 = find_mc(4'd10, 1'b0);
    send_frame(BCAST, 64, 1, 0, 1, "R11 R5 broadcast accepted at reset");
    send_frame(hit10, 64, 1, 1, 1, "R11 R6 multicast index 10 accepted");
    send_frame(miss10, 64, 1, 0, 0, "R11 R6 multicast other index rejected");
    send_frame(BCAST, 63, 1, 0, 0, "R8 R11 63-byte runt rejected");
    send_frame(BCAST, 64, 0, 0, 0, "R9 R11 bad crc rejected");
    send_frame(48'h0000_0000_0000, 64, 1, 0, 1, "R11 station zero matches");
  endtask

  task automatic t_station;
    set_station(STA);
    send_frame(STA, 70, 1, 0, 1, "R3 unicast equal to station accepted");
    send_frame(STA ^ 48'h0100_0000_0000, 64, 1, 0, 0, "R3 unicast mismatch rejected");
    cfg_write(3'd0, 16'h0000);
    set_station(48'h0C0A_0806_0403);
    cfg_write(3'd4, 16'h0000);
    send_frame(48'h0C0A_0806_0403, 64, 1, 0, 1, "R4 multicast-type station accepted with enables off");
  endtask

  task automatic t_bcast;
    set_station(STA);
    cfg_write(3'd0, 16'h0002);
    send_frame(BCAST, 64, 1, 0, 0, "R5 broadcast rejected with enable off");
    cfg_write(3'd0, 16'h0001);
    send_frame(BCAST, 64, 1, 0, 1, "R5 broadcast accepted with enable on");
  endtask

  task automatic t_hash;
    logic [47:0] a;
    cfg_write(3'd0, 16'h0002);
    cfg_write(3'd4, 16'hFFFF);
    send_frame(48'h6655_4433_2213, 64, 1, 0, 1, "R7 full table accepts");
    send_frame(find_mc(4'd3, 1'b1), 64, 1, 0, 1, "R7 full table accepts second");
    cfg_write(3'd4, 16'h0000);
    send_frame(48'h6655_4433_2213, 64, 1, 0, 0, "R7 empty table rejects");
    a = find_mc(4'd5, 1'b1);
    cfg_write(3'd4, 16'h0020);
    send_frame(a, 64, 1, 0, 1, "R6 single table bit 5 selects");
    send_frame(find_mc(4'd5, 1'b0), 64, 1, 0, 0, "R6 other index rejected");
    cfg_write(3'd0, 16'h0000);
    send_frame(a, 64, 1, 0, 0, "R6 multicast enable off rejects");
  endtask

  task automatic t_policies;
    cfg_write(3'd0, 16'h0001);
    send_frame(BCAST, 64, 1, 0, 1, "R8 64 bytes not a runt");
    cfg_write(3'd0, 16'h0005);
    send_frame(BCAST, 40, 1, 0, 1, "R8 runt accepted with enable");
    cfg_write(3'd0, 16'h0009);
    send_frame(BCAST, 64, 0, 0, 1, "R9 bad crc accepted with enable");
    cfg_write(3'd0, 16'h000F);
    send_frame(BCAST, 5, 1, 0, 0, "R10 five bytes rejected");
    send_frame(BCAST, 6, 1, 0, 1, "R10 six bytes accepted");
    send_frame(BCAST, 1, 1, 0, 0, "R10 single byte frame rejected");
  endtask

  task automatic t_midwrite;
    cfg_write(3'd0, 16'h0001);
    send_frame(BCAST, 64, 1, 0, 1, "R12 mid-frame write ignored by this frame", 1, 3'd0, 16'h0000);
    send_frame(BCAST, 64, 1, 0, 0, "R12 R13 write applies to next frame");
  endtask

  task automatic t_outside;
    cfg_write(3'd0, 16'h000F);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 7); in_crc_ok = 1'b1; in_data = 8'hFF;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    check(dec_valid == 1'b0, "R1 bytes outside a frame give no verdict", 32'(dec_valid), 0);
    @(negedge clk);
    check(dec_valid == 1'b0, "R1 still no verdict", 32'(dec_valid), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_defaults();
    t_station();
    t_bcast();
    t_hash();
    t_policies();
    t_midwrite();
    t_outside();
    finish_run();
  end

endmodule